// File: doc/BRIEF.md
# Lockable Multi-Mode Watchdog Timer

This block is a watchdog timer with a single control/status register behind a simple write strobe and a read port. Software picks a timeout code and one of four expiry behaviours, then sets the enable bit. From then on it must keep writing a retrigger bit before the countdown runs out. The countdown advances on a slow timebase tick, nominally one pulse every 125 ms, that the system supplies.

Four expiry behaviours are available: flag only, hard-reset request, interrupt, and a two-stage behaviour. The two-stage behaviour raises the interrupt first and escalates to a reset request if software stays silent for a second period. Once the enable bit is set, the configuration fields are frozen until the next power-on reset. The sticky timeout flag sits in the power-on domain, so software can still read it after a warm reset that the watchdog itself caused. A routing bit sends the interrupt to either a non-maskable line or an ordinary interrupt line.

Top module: `wdt_lock`

## Requirements
- R1: A started countdown expires on the 2^c-th tick after it is loaded, where c is the period code in bits [3:0], for codes 0 to 11. Codes 12 to 15 behave as 2048 ticks.
- R2: Register bits are [3:0] period code, [5:4] mode (0 flag-only, 1 reset, 2 interrupt, 3 two-stage), [6] route to NMI, [7] enable, [8] retrigger (always reads 0), [9] timeout flag. After power-on the register reads 0 and no expiry, interrupt or reset request occurs. A write that sets enable also applies the mode, route and period written with it, and loads the countdown.
- R3: While enabled, writes to bits [7:0] are ignored until power-on reset.
- R4: Writing 1 to the retrigger bit while enabled reloads the full period and restarts a stopped countdown. A write with that bit at 0 leaves the countdown untouched.
- R5: Every expiry sets the timeout flag, which stays set until software writes 1 to bit 9. If an expiry and a clear happen in the same cycle, the flag ends up set.
- R6: In flag-only mode an expiry raises no interrupt and no reset request. The countdown then stops until a retrigger.
- R7: In reset mode an expiry gives a reset request pulse exactly one clock long. A warm reset keeps the flag and the configuration, and reloads the countdown. Only power-on reset clears them.
- R8: In interrupt mode and two-stage mode, the interrupt output is a level that is high while the flag is set. It appears on nmi_o when bit 6 is 1 and on irq_o otherwise, and never on both.
- R9: In two-stage mode the first expiry sets the flag and reloads the countdown without a reset request. A second expiry with no retrigger in between gives a reset request pulse. A retrigger restores the first stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous warm reset |
| por_ni | input | 1 | Active-low asynchronous power-on reset |
| tick_i | input | 1 | Timebase pulse, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Register write data |
| rd_data_o | output | DATA_W | Register read data |
| rst_req_o | output | 1 | Hard-reset request pulse |
| irq_o | output | 1 | Ordinary interrupt level |
| nmi_o | output | 1 | Non-maskable interrupt level |

## Verification
The countdown is driven with exact tick counts of one less than the period and of the full period, for short, mid-range and out-of-range codes. This separates an off-by-one load from a correct one and shows that unused codes saturate. Randomized runs place a retrigger at an arbitrary point inside the period and confirm that the next expiry is counted from that write. Directed sequences cover the following cases:
- rewriting the configuration after enable
- a clear that lands in the same cycle as an expiry
- extra ticks after a flag-only expiry
- warm resets after a reset-mode expiry
- the two-stage escalation with and without a retrigger between the expiries

Together these separate the mode behaviours, the lock, and the split between the two reset domains.

// File: rtl/wdt_lock_pkg.sv
package wdt_lock_pkg;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [1:0] {
    MODE_FLAG  = 2'd0,
    MODE_RESET = 2'd1,
    MODE_IRQ   = 2'd2,
    MODE_DUAL  = 2'd3
  } wdt_mode_e;

  // register image, MSB first: bit 9 down to bit 0
  typedef struct packed {
    logic              flag;
    logic              retrig;
    logic              enable;
    logic              nmi_sel;
    wdt_mode_e         mode;
    logic [CODE_W-1:0] period;
  } wdt_reg_t;
endpackage

// File: rtl/wdt_lock_cfg.sv
module wdt_lock_cfg
  import wdt_lock_pkg::*;
(
  input  logic              clk_i,
  input  logic              por_ni,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] wr_period_i,
  input  wdt_mode_e         wr_mode_i,
  input  logic              wr_nmi_sel_i,
  input  logic              wr_enable_i,
  output logic [CODE_W-1:0] period_o,
  output wdt_mode_e         mode_o,
  output logic              nmi_sel_o,
  output logic              enable_o,
  output logic              start_o
);
  logic wr_open;
  assign wr_open = wr_en_i & ~enable_o;
  assign start_o = wr_open & wr_enable_i;

  // power-on domain only: lock survives warm reset
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      period_o  <= '0;
      mode_o    <= MODE_FLAG;
      nmi_sel_o <= 1'b0;
      enable_o  <= 1'b0;
    end else if (wr_open) begin
      period_o  <= wr_period_i;
      mode_o    <= wr_mode_i;
      nmi_sel_o <= wr_nmi_sel_i;
      enable_o  <= wr_enable_i;
    end
  end
endmodule

// File: rtl/wdt_lock_cnt.sv
module wdt_lock_cnt
  import wdt_lock_pkg::*;
#(
  parameter int unsigned MAX_EXP = 11,
  localparam int unsigned CNT_W = MAX_EXP + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              start_i,
  input  logic [CODE_W-1:0] start_code_i,
  input  logic              retrig_i,
  input  logic              tick_i,
  input  logic              stop_i,
  output logic              expire_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic              pend_q;
  logic              halt_q;
  logic [CODE_W-1:0] sel_code;
  logic [CNT_W-1:0]  reload;

  function automatic logic [CNT_W-1:0] reload_of(input logic [CODE_W-1:0] c);
    logic [CNT_W:0] p;
    if (c > CODE_W'(MAX_EXP)) p = (CNT_W+1)'(1) << MAX_EXP;
    else                      p = (CNT_W+1)'(1) << c;
    p = p - 1'b1;
    return p[CNT_W-1:0];
  endfunction

  assign sel_code = start_i ? start_code_i : code_i;
  assign reload   = reload_of(sel_code);

  // software writes take priority over a coincident tick
  assign expire_o = en_i & tick_i & ~halt_q & ~pend_q & (cnt_q == '0)
                  & ~start_i & ~retrig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b1;
      halt_q <= 1'b0;
    end else if (start_i || retrig_i) begin
      cnt_q  <= reload;
      pend_q <= 1'b0;
      halt_q <= 1'b0;
    end else if (pend_q) begin
      cnt_q  <= reload;
      pend_q <= 1'b0;
    end else if (expire_o) begin
      cnt_q  <= reload;
      halt_q <= stop_i;
    end else if (en_i && tick_i && !halt_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_lock_exp.sv
module wdt_lock_exp
  import wdt_lock_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      por_ni,
  input  logic      expire_i,
  input  wdt_mode_e mode_i,
  input  logic      en_i,
  input  logic      nmi_sel_i,
  input  logic      retrig_i,
  input  logic      clr_i,
  output logic      flag_o,
  output logic      stop_o,
  output logic      rst_req_o,
  output logic      irq_o,
  output logic      nmi_o
);
  logic stage_q;
  logic int_act;

  assign stop_o  = (mode_i != MODE_DUAL) | stage_q;
  assign int_act = flag_o & en_i & ((mode_i == MODE_IRQ) | (mode_i == MODE_DUAL));
  assign nmi_o   = int_act & nmi_sel_i;
  assign irq_o   = int_act & ~nmi_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q   <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      rst_req_o <= expire_i & ((mode_i == MODE_RESET) | ((mode_i == MODE_DUAL) & stage_q));
      if (retrig_i)                              stage_q <= 1'b0;
      else if (expire_i && mode_i == MODE_DUAL)  stage_q <= 1'b1;
    end
  end

  // sticky flag lives in power-on domain; set wins over clear
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)       flag_o <= 1'b0;
    else if (expire_i) flag_o <= 1'b1;
    else if (clr_i)    flag_o <= 1'b0;
  end
endmodule

// File: rtl/wdt_lock.sv
module wdt_lock
  import wdt_lock_pkg::*;
#(
  parameter int unsigned MAX_EXP = 11,
  parameter int unsigned DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rst_req_o,
  output logic              irq_o,
  output logic              nmi_o
);
  localparam int unsigned REG_W = $bits(wdt_reg_t);

  wdt_reg_t          wr_f, rd_f;
  logic [CODE_W-1:0] period;
  wdt_mode_e         mode;
  logic              nmi_sel, enable, start, retrig, clr;
  logic              expire, stop, flag;
  logic              warm_rst_n;
  logic              unused_hi;

  assign wr_f       = wdt_reg_t'(wr_data_i[REG_W-1:0]);
  assign unused_hi  = ^wr_data_i[DATA_W-1:REG_W];
  assign warm_rst_n = rst_ni & por_ni;
  assign retrig     = wr_en_i & wr_f.retrig & enable;
  assign clr        = wr_en_i & wr_f.flag;

  wdt_lock_cfg u_cfg (
    .clk_i        (clk_i),
    .por_ni       (por_ni),
    .wr_en_i      (wr_en_i),
    .wr_period_i  (wr_f.period),
    .wr_mode_i    (wr_f.mode),
    .wr_nmi_sel_i (wr_f.nmi_sel),
    .wr_enable_i  (wr_f.enable),
    .period_o     (period),
    .mode_o       (mode),
    .nmi_sel_o    (nmi_sel),
    .enable_o     (enable),
    .start_o      (start)
  );

  wdt_lock_cnt #(.MAX_EXP(MAX_EXP)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (warm_rst_n),
    .en_i         (enable),
    .code_i       (period),
    .start_i      (start),
    .start_code_i (wr_f.period),
    .retrig_i     (retrig),
    .tick_i       (tick_i),
    .stop_i       (stop),
    .expire_o     (expire)
  );

  wdt_lock_exp u_exp (
    .clk_i     (clk_i),
    .rst_ni    (warm_rst_n),
    .por_ni    (por_ni),
    .expire_i  (expire),
    .mode_i    (mode),
    .en_i      (enable),
    .nmi_sel_i (nmi_sel),
    .retrig_i  (retrig),
    .clr_i     (clr),
    .flag_o    (flag),
    .stop_o    (stop),
    .rst_req_o (rst_req_o),
    .irq_o     (irq_o),
    .nmi_o     (nmi_o)
  );

  always_comb begin
    rd_f         = '0;
    rd_f.flag    = flag;
    rd_f.enable  = enable;
    rd_f.nmi_sel = nmi_sel;
    rd_f.mode    = mode;
    rd_f.period  = period;
  end
  assign rd_data_o = DATA_W'(rd_f);
endmodule

// File: rtl/wdt_lock_chk.sv
module wdt_lock_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              por_ni,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rst_req_o,
  input logic              irq_o,
  input logic              nmi_o
);
  assert_rst_pulse_R7: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    rst_req_o |=> !rst_req_o);

  assert_one_line_R8: assert property (@(posedge clk_i) disable iff (!por_ni)
    !(irq_o && nmi_o));

  assert_cfg_lock_R3: assert property (@(posedge clk_i) disable iff (!por_ni)
    $past(rd_data_o[7]) |-> $stable(rd_data_o[7:0]));

  assert_flag_sticky_R5: assert property (@(posedge clk_i) disable iff (!por_ni)
    ($past(rd_data_o[9]) && !$past(wr_en_i)) |-> rd_data_o[9]);

  assert_flag_mode_quiet_R6: assert property (@(posedge clk_i) disable iff (!por_ni || !rst_ni)
    (rd_data_o[7] && rd_data_o[5:4] == 2'd0) |-> (!rst_req_o && !irq_o && !nmi_o));

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!por_ni)
    !rd_data_o[7] |-> (!rst_req_o && !irq_o && !nmi_o && !rd_data_o[9]));
endmodule

bind wdt_lock wdt_lock_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .por_ni    (por_ni),
  .wr_en_i   (wr_en_i),
  .rd_data_o (rd_data_o),
  .rst_req_o (rst_req_o),
  .irq_o     (irq_o),
  .nmi_o     (nmi_o)
);

// File: tb/tb_wdt_lock.sv
module tb_wdt_lock;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0, por_n = 1'b0;
  logic          tick = 1'b0, wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rst_req, irq, nmi;
  int            checks = 0, errors = 0, rst_seen = 0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_lock dut (
    .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n), .tick_i(tick),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .rst_req_o(rst_req), .irq_o(irq), .nmi_o(nmi)
  );

  function automatic logic [DW-1:0] cfgw(bit flag, bit rt, bit en, bit ns, int mode, int code);
    return DW'({flag, rt, en, ns, 2'(mode), 4'(code)});
  endfunction

  function automatic int lim(int code);
    return (code > 11) ? 2048 : (1 << code);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [DW-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (rst_req) rst_seen++;
    end
  endtask

  task automatic por_cycle();
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1; rst_seen = 0;
    @(negedge clk);
  endtask

  task automatic warm_cycle();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R2 act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    por_cycle();
    // R2 reset state and idle
    chk("R2 reset rd", int'(rd_data), 0);
    chk("R2 reset outs", int'({rst_req, irq, nmi}), 0);
    wr(cfgw(0, 1, 0, 0, 1, 0));
    ticks(5);
    chk("R2 disabled no flag", int'(rd_data[9]), 0);
    chk("R2 disabled no rst", rst_seen, 0);

    // R1 / R3 lock: timer mode code 3
    por_cycle();
    wr(cfgw(0, 0, 1, 0, 0, 3));
    wr(cfgw(0, 0, 0, 1, 2, 1));
    chk("R3 locked cfg", int'(rd_data[7:0]), 8'h83);
    ticks(7);
    chk("R1 code3 before", int'(rd_data[9]), 0);
    ticks(1);
    chk("R1 code3 at limit", int'(rd_data[9]), 1);
    // R6 flag-only
    chk("R6 no irq/nmi", int'({irq, nmi}), 0);
    chk("R6 no rst", rst_seen, 0);
    wr(cfgw(1, 0, 1, 0, 0, 3));
    chk("R5 w1c", int'(rd_data[9]), 0);
    ticks(20);
    chk("R6 halted", int'(rd_data[9]), 0);
    // R4 retrigger
    wr(cfgw(0, 1, 1, 0, 0, 3));
    ticks(5);
    wr(cfgw(0, 1, 1, 0, 0, 3));
    ticks(7);
    chk("R4 retrig reload", int'(rd_data[9]), 0);
    wr(cfgw(0, 0, 1, 0, 0, 3));
    ticks(1);
    chk("R4 zero no effect", int'(rd_data[9]), 1);
    wr(cfgw(0, 0, 1, 0, 0, 3));
    chk("R5 write 0 keeps", int'(rd_data[9]), 1);

    // R5 set wins over clear
    por_cycle();
    wr(cfgw(0, 0, 1, 0, 0, 0));
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_data = cfgw(1, 0, 0, 0, 0, 0);
    @(negedge clk); tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk("R5 set wins", int'(rd_data[9]), 1);

    // R1 unused code saturates
    por_cycle();
    wr(cfgw(0, 0, 1, 0, 0, 13));
    ticks(2047);
    chk("R1 code13 before", int'(rd_data[9]), 0);
    ticks(1);
    chk("R1 code13 at 2048", int'(rd_data[9]), 1);

    // R7 reset mode
    por_cycle();
    wr(cfgw(0, 0, 1, 0, 1, 0));
    ticks(1);
    chk("R7 rst pulse", rst_seen, 1);
    @(negedge clk);
    chk("R7 pulse one clk", int'(rst_req), 0);
    chk("R7 no irq", int'({irq, nmi}), 0);
    warm_cycle();
    chk("R7 flag survives", int'(rd_data[9]), 1);
    chk("R7 cfg survives", int'(rd_data[7:0]), 8'h90);
    ticks(1);
    chk("R7 counts after warm", rst_seen, 2);
    por_cycle();
    chk("R7 por clears", int'(rd_data), 0);

    // R8 interrupt routing
    wr(cfgw(0, 0, 1, 1, 2, 0));
    ticks(1);
    chk("R8 nmi route", int'({irq, nmi}), 1);
    wr(cfgw(1, 0, 1, 1, 2, 0));
    chk("R8 level drops", int'({irq, nmi}), 0);
    por_cycle();
    wr(cfgw(0, 0, 1, 0, 2, 0));
    ticks(1);
    chk("R8 irq route", int'({irq, nmi}), 2);
    chk("R8 no rst", rst_seen, 0);

    // R9 two-stage
    por_cycle();
    wr(cfgw(0, 0, 1, 0, 3, 1));
    ticks(2);
    chk("R9 stage1 flag", int'(rd_data[9]), 1);
    chk("R9 stage1 irq", int'(irq), 1);
    chk("R9 stage1 no rst", rst_seen, 0);
    ticks(2);
    chk("R9 stage2 rst", rst_seen, 1);
    por_cycle();
    wr(cfgw(0, 0, 1, 0, 3, 1));
    ticks(2);
    wr(cfgw(0, 1, 1, 0, 3, 1));
    ticks(2);
    chk("R9 retrig resets stage", rst_seen, 0);
    ticks(2);
    chk("R9 escalates later", rst_seen, 1);

    // R1 R4 R8 random
    for (int it = 0; it < 16; it++) begin
      int code, mode, k;
      code = int'($urandom_range(0, 5));
      mode = ($urandom_range(0, 1) == 1) ? 2 : 0;
      k    = int'($urandom_range(0, lim(code) - 1));
      por_cycle();
      wr(cfgw(0, 0, 1, 0, mode, code));
      ticks(k);
      wr(cfgw(0, 1, 1, 0, mode, code));
      ticks(lim(code) - 1);
      chk("R4 rand before", int'(rd_data[9]), 0);
      ticks(1);
      chk("R1 rand expiry", int'(rd_data[9]), 1);
      chk("R8 rand irq", int'(irq), (mode == 2) ? 1 : 0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule